// File: doc/BRIEF.md
# DMA Channel Interrupt and Error Status Unit

This unit is the shared status and control register block of a multi-channel DMA engine. Each channel's datapath reports three kinds of event to it: a completion pulse, a terminate event and a bus error. The unit turns these into sticky per-channel flags. It applies a per-channel interrupt enable to the completion flags. It decides which channels are really in error and drives one combined interrupt line. It also holds the per-channel freeze (pause) controls, self-clearing channel reset requests, a per-channel next-command pointer and a per-channel semaphore counter, all of which the channel datapaths consume.

Software reaches the unit over a simple single-cycle register bus. A write is taken on the clock edge, and read data is a combinational function of the address. Each of the four shared registers has three addresses. A write at the base address replaces the register. A write at base+4 ORs the written ones into it, and a write at base+8 clears the bits written as one. A read at any of the three returns the same value. Software therefore never needs a read-modify-write to touch one channel. A terminate that arrives together with completion is treated as a normal end of transfer. A terminate with no completion, or any bus error, is reported as an error.

Top module: `dmas_status_top`

## Requirements
- R1: After a synchronous reset every register reads zero, and irq, chan_err, chan_freeze, chan_reset, chan_sema_nz, chan_cmd_addr, burst_en and burst8_en are all zero.
- R2: For the registers at 0x000, 0x010, 0x020 and 0x030, a write at the base address replaces the value. A write at base+0x4 sets the bits written as one, and a write at base+0x8 clears the bits written as one. A read at base, base+0x4 or base+0x8 returns the register value. base+0xC reads zero and ignores writes.
- R3: Register 0x010 holds a sticky completion flag for channel n in bit n and its interrupt enable in bit 16+n. A completion event sets the flag on the next edge and wins over a software clear in the same cycle.
- R4: Register 0x020 holds a terminate flag for channel n in bit n and a bus-error qualifier in bit 16+n. A terminate event sets bit n. A bus-error event sets both bit n and bit 16+n. Both kinds of event win over a same-cycle software clear.
- R5: chan_err[n] is high when both error bits of channel n are set, or when the terminate bit is set while the qualifier and the completion flag are both clear. A terminate that arrives in the same cycle as completion therefore never shows as an error.
- R6: irq is the OR, over all channels, of (completion flag AND enable) and of chan_err.
- R7: Bits [15:0] of register 0x030 are the per-channel freeze controls and drive chan_freeze directly.
- R8: Writing one to bit 16+n of 0x030 raises chan_reset[n] for exactly one cycle, after which the bit clears itself. At the end of that cycle channel n's completion, terminate, qualifier and freeze bits and its semaphore clear. Its enable, its pointer and all other channels are unaffected.
- R9: Channel n's 32-bit next-command pointer is at 0x110+n*0x70 and drives chan_cmd_addr[32n+31:32n]. Its 8-bit semaphore is at 0x140+n*0x70 and reads back in bits [7:0]. A write to the semaphore adds wdata[7:0]. A sema_dec pulse subtracts one, except that it is ignored at zero. chan_sema_nz[n] is high when the count is non-zero.
- R10: In register 0x000, bit 28 drives burst_en and bit 29 drives burst8_en. All other bits read zero.
- R11: Addresses that are not mapped read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, taken on the clock edge |
| bus_addr | input | 12 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_done | input | 16 | Per-channel completion pulses |
| ev_term | input | 16 | Per-channel terminate pulses |
| ev_buserr | input | 16 | Per-channel bus-error pulses |
| sema_dec | input | 16 | Per-channel semaphore decrement pulses |
| irq | output | 1 | Combined interrupt |
| chan_err | output | 16 | Per-channel qualified error indication |
| chan_freeze | output | 16 | Per-channel freeze controls |
| chan_reset | output | 16 | Per-channel one-cycle reset pulses |
| chan_sema_nz | output | 16 | Per-channel semaphore non-zero |
| chan_cmd_addr | output | 512 | Per-channel next-command pointers, channel n at bits [32n+31:32n] |
| burst_en | output | 1 | Burst enable |
| burst8_en | output | 1 | 8-beat burst enable |

## Verification
The error classification is tried with a lone terminate, a terminate followed later by completion, a terminate together with completion, and a bus error together with completion. These four cases separate the real-error cases from the benign terminate. Alias writes are tried on each shared register, and some are made in the same cycle as hardware events. This shows whether the set alias, the clear alias and event priority are applied per bit rather than to the whole word. A long random phase mixes events, writes to every alias, unmapped addresses and channel resets. The phase is compared every cycle against a behavioural model. This exposes errors in the interaction between reset pulses, semaphore counting and the sticky flags.

// File: rtl/dmas_pkg.sv
// Shared constants and helpers for the DMA status unit.
// Assumes byte addressing and 32-bit registers. Per-channel fields sit at bit n
// and bit FIELD_OFS+n of the shared registers.
package dmas_pkg;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_BASE = 2'd1,
        WK_SET  = 2'd2,
        WK_CLR  = 2'd3
    } wkind_e;

    localparam int REG_W     = 32;
    localparam int FIELD_OFS = 16;
    localparam int SEMA_W    = 8;
    localparam int CMD_BASE  = 'h110;
    localparam int SEMA_BASE = 'h140;
    localparam int CH_STRIDE = 'h070;
    localparam int CFG_B1    = 28;
    localparam int CFG_B8    = 29;

    // Next value of one register bit under a base, set-alias or clear-alias write.
    function automatic logic apply_bit(wkind_e k, logic cur, logic w);
        case (k)
            WK_BASE: return w;
            WK_SET:  return cur | w;
            WK_CLR:  return cur & ~w;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/dmas_addr_dec.sv
// Address decoder for the DMA status unit.
// Maps the four shared registers, each with base, set and clear aliases, and the
// per-channel pointer and semaphore words at a fixed stride. Read selects ignore
// bus_wen. Write kinds are WK_NONE unless bus_wen is high.
module dmas_addr_dec
    import dmas_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 12
) (
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    output wkind_e            wk_cfg,
    output wkind_e            wk_done,
    output wkind_e            wk_err,
    output wkind_e            wk_ctl,
    output logic [3:0]        rsel,
    output logic [NCH-1:0]    cmd_sel,
    output logic [NCH-1:0]    sema_sel
);

    logic   in_status;
    wkind_e kind;

    // Status region check and alias kind from the low nibble.
    always_comb begin
        in_status = (addr[ADDR_W-1:6] == '0);
        case (addr[3:0])
            4'h0:    kind = WK_BASE;
            4'h4:    kind = WK_SET;
            4'h8:    kind = WK_CLR;
            default: kind = WK_NONE;
        endcase
    end

    // One read select per shared register, valid at any of its aliases.
    always_comb begin
        rsel = '0;
        if (in_status && kind != WK_NONE)
            rsel[addr[5:4]] = 1'b1;
    end

    // Write kinds are gated by the strobe and the register select.
    always_comb begin
        wk_cfg  = (wen && rsel[0]) ? kind : WK_NONE;
        wk_done = (wen && rsel[1]) ? kind : WK_NONE;
        wk_err  = (wen && rsel[2]) ? kind : WK_NONE;
        wk_ctl  = (wen && rsel[3]) ? kind : WK_NONE;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chsel
        localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_BASE  + n * CH_STRIDE);
        localparam logic [ADDR_W-1:0] SEMA_A = ADDR_W'(SEMA_BASE + n * CH_STRIDE);
        assign cmd_sel[n]  = (addr == CMD_A);
        assign sema_sel[n] = (addr == SEMA_A);
    end

endmodule

// File: rtl/dmas_chan_slice.sv
// State of one DMA channel inside the status unit: sticky completion, terminate
// and bus-error flags, the interrupt enable, freeze, a self-clearing reset request,
// the next-command pointer and the semaphore.
// Assumes the decoder gives at most one write kind per register per cycle.
// Hardware events win over software clears. The reset request wins over everything.
module dmas_chan_slice
    import dmas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wkind_e            wk_done,
    input  wkind_e            wk_err,
    input  wkind_e            wk_ctl,
    input  logic              w_lo,
    input  logic              w_hi,
    input  logic              cmd_wr,
    input  logic              sema_wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              ev_done,
    input  logic              ev_term,
    input  logic              ev_buserr,
    input  logic              sema_dec,
    output logic              done_q,
    output logic              en_q,
    output logic              term_q,
    output logic              be_q,
    output logic              frz_q,
    output logic              rst_q,
    output logic [SEMA_W-1:0] sema_q,
    output logic [REG_W-1:0]  cmd_q,
    output logic              err
);

    logic [SEMA_W-1:0] sema_add;
    logic              sema_sub;

    // Semaphore increment from a write and decrement that stops at zero.
    always_comb begin
        sema_add = sema_wr ? wdata[SEMA_W-1:0] : '0;
        sema_sub = sema_dec && (sema_q != '0);
    end

    // Sticky flags, freeze and reset request, with the channel reset taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            en_q   <= 1'b0;
            term_q <= 1'b0;
            be_q   <= 1'b0;
            frz_q  <= 1'b0;
            rst_q  <= 1'b0;
        end else begin
            en_q  <= apply_bit(wk_done, en_q, w_hi);
            rst_q <= apply_bit(wk_ctl, 1'b0, w_hi);
            if (rst_q) begin
                done_q <= 1'b0;
                term_q <= 1'b0;
                be_q   <= 1'b0;
                frz_q  <= 1'b0;
            end else begin
                done_q <= apply_bit(wk_done, done_q, w_lo) | ev_done;
                term_q <= apply_bit(wk_err, term_q, w_lo) | ev_term | ev_buserr;
                be_q   <= apply_bit(wk_err, be_q, w_hi) | ev_buserr;
                frz_q  <= apply_bit(wk_ctl, frz_q, w_lo);
            end
        end
    end

    // Semaphore counter, cleared by the channel reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_q)
            sema_q <= '0;
        else
            sema_q <= sema_q + sema_add - SEMA_W'(sema_sub);
    end

    // Next-command pointer, written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (cmd_wr)
            cmd_q <= wdata;
    end

    // Error qualification: a bus error, or a terminate with no completion.
    assign err = (term_q & be_q) | (term_q & ~be_q & ~done_q);

    // R3
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && !rst_q) |=> done_q);

    // R4
    buserr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_buserr && !rst_q) |=> (term_q && be_q));

    // R8
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> (!done_q && !term_q && !be_q && !frz_q && sema_q == '0));

    // R9
    sema_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sema_q == '0 && !sema_wr && !rst_q) |=> (sema_q == '0));

endmodule

// File: rtl/dmas_status_top.sv
// Top of the DMA status unit. Instantiates one slice per channel and the address
// decoder. It holds the burst configuration bits, builds the read data and ORs
// the qualified per-channel sources into one interrupt.
// Assumes NCH <= 16, so every per-channel field fits its half-word.
module dmas_status_top
    import dmas_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wen,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NCH-1:0]       ev_done,
    input  logic [NCH-1:0]       ev_term,
    input  logic [NCH-1:0]       ev_buserr,
    input  logic [NCH-1:0]       sema_dec,
    output logic                 irq,
    output logic [NCH-1:0]       chan_err,
    output logic [NCH-1:0]       chan_freeze,
    output logic [NCH-1:0]       chan_reset,
    output logic [NCH-1:0]       chan_sema_nz,
    output logic [NCH*REG_W-1:0] chan_cmd_addr,
    output logic                 burst_en,
    output logic                 burst8_en
);

    wkind_e            wk_cfg, wk_done, wk_err, wk_ctl;
    logic [3:0]        rsel;
    logic [NCH-1:0]    cmd_sel, sema_sel;
    logic [NCH-1:0]    done_v, en_v, term_v, be_v;
    logic [SEMA_W-1:0] sema_v [NCH];
    logic [REG_W-1:0]  cmd_v  [NCH];

    dmas_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .wen      (bus_wen),
        .addr     (bus_addr),
        .wk_cfg   (wk_cfg),
        .wk_done  (wk_done),
        .wk_err   (wk_err),
        .wk_ctl   (wk_ctl),
        .rsel     (rsel),
        .cmd_sel  (cmd_sel),
        .sema_sel (sema_sel)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dmas_chan_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .wk_done   (wk_done),
            .wk_err    (wk_err),
            .wk_ctl    (wk_ctl),
            .w_lo      (bus_wdata[n]),
            .w_hi      (bus_wdata[FIELD_OFS+n]),
            .cmd_wr    (bus_wen && cmd_sel[n]),
            .sema_wr   (bus_wen && sema_sel[n]),
            .wdata     (bus_wdata),
            .ev_done   (ev_done[n]),
            .ev_term   (ev_term[n]),
            .ev_buserr (ev_buserr[n]),
            .sema_dec  (sema_dec[n]),
            .done_q    (done_v[n]),
            .en_q      (en_v[n]),
            .term_q    (term_v[n]),
            .be_q      (be_v[n]),
            .frz_q     (chan_freeze[n]),
            .rst_q     (chan_reset[n]),
            .sema_q    (sema_v[n]),
            .cmd_q     (cmd_v[n]),
            .err       (chan_err[n])
        );
        assign chan_sema_nz[n]                = (sema_v[n] != '0);
        assign chan_cmd_addr[n*REG_W +: REG_W] = cmd_v[n];
    end

    // Burst configuration bits with alias write support.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_en  <= 1'b0;
            burst8_en <= 1'b0;
        end else begin
            burst_en  <= apply_bit(wk_cfg, burst_en,  bus_wdata[CFG_B1]);
            burst8_en <= apply_bit(wk_cfg, burst8_en, bus_wdata[CFG_B8]);
        end
    end

    // Combined interrupt from enabled completions and qualified errors.
    assign irq = |(done_v & en_v) | (|chan_err);

    // Read data mux; aliases share their base register's value.
    always_comb begin
        bus_rdata = '0;
        if (rsel[0]) begin
            bus_rdata[CFG_B1] = burst_en;
            bus_rdata[CFG_B8] = burst8_en;
        end
        for (int n = 0; n < NCH; n++) begin
            if (rsel[1]) begin
                bus_rdata[n]           = done_v[n];
                bus_rdata[FIELD_OFS+n] = en_v[n];
            end
            if (rsel[2]) begin
                bus_rdata[n]           = term_v[n];
                bus_rdata[FIELD_OFS+n] = be_v[n];
            end
            if (rsel[3]) begin
                bus_rdata[n]           = chan_freeze[n];
                bus_rdata[FIELD_OFS+n] = chan_reset[n];
            end
            if (cmd_sel[n])  bus_rdata = cmd_v[n];
            if (sema_sel[n]) bus_rdata = REG_W'(sema_v[n]);
        end
    end

    // R6
    irq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_err) |-> irq);

    // R5
    err_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_err & ~term_v) == '0));

endmodule

// File: tb/test_dmas_status_top.sv
`timescale 1ns/1ps
module test_dmas_status_top;

    localparam int NCH = 16;
    localparam int WD_CYC = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wen = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    ev_done = '0, ev_term = '0, ev_buserr = '0, sema_dec = '0;
    logic              irq;
    logic [NCH-1:0]    chan_err, chan_freeze, chan_reset, chan_sema_nz;
    logic [NCH*32-1:0] chan_cmd_addr;
    logic              burst_en, burst8_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dmas_status_top i_dmas_status_top (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
        .ev_term(ev_term), .ev_buserr(ev_buserr), .sema_dec(sema_dec), .irq(irq),
        .chan_err(chan_err), .chan_freeze(chan_freeze), .chan_reset(chan_reset),
        .chan_sema_nz(chan_sema_nz), .chan_cmd_addr(chan_cmd_addr),
        .burst_en(burst_en), .burst8_en(burst8_en)
    );

    // Behavioural reference state.
    bit m_done[NCH], m_en[NCH], m_term[NCH], m_be[NCH], m_frz[NCH], m_rst[NCH];
    int m_sema[NCH];
    logic [31:0] m_cmd[NCH];
    bit m_b1, m_b8;

    function automatic int mkind(int r);
        int sub;
        if (!bus_wen || bus_addr >= 12'h040 || (bus_addr >> 4) != r) return 0;
        sub = bus_addr & 'hF;
        if (sub == 0) return 1;
        if (sub == 4) return 2;
        if (sub == 8) return 3;
        return 0;
    endfunction

    function automatic bit mapply(int k, bit cur, bit w);
        if (k == 1) return w;
        if (k == 2) return cur | w;
        if (k == 3) return cur & ~w;
        return cur;
    endfunction

    function automatic bit m_err(int n);
        return (m_term[n] && m_be[n]) || (m_term[n] && !m_be[n] && !m_done[n]);
    endfunction

    always @(posedge clk) begin
        int k0, k1, k2, k3;
        bit r, lo, hi;
        if (!rst_n) begin
            for (int n = 0; n < NCH; n++) begin
                m_done[n] = 0; m_en[n] = 0; m_term[n] = 0; m_be[n] = 0;
                m_frz[n] = 0; m_rst[n] = 0; m_sema[n] = 0; m_cmd[n] = '0;
            end
            m_b1 = 0; m_b8 = 0;
        end else begin
            k0 = mkind(0); k1 = mkind(1); k2 = mkind(2); k3 = mkind(3);
            m_b1 = mapply(k0, m_b1, bus_wdata[28]);
            m_b8 = mapply(k0, m_b8, bus_wdata[29]);
            for (int n = 0; n < NCH; n++) begin
                r = m_rst[n]; lo = bus_wdata[n]; hi = bus_wdata[16+n];
                m_en[n] = mapply(k1, m_en[n], hi);
                m_rst[n] = mapply(k3, 1'b0, hi);
                if (r) begin
                    m_done[n] = 0; m_term[n] = 0; m_be[n] = 0; m_frz[n] = 0; m_sema[n] = 0;
                end else begin
                    m_done[n] = mapply(k1, m_done[n], lo) | ev_done[n];
                    m_term[n] = mapply(k2, m_term[n], lo) | ev_term[n] | ev_buserr[n];
                    m_be[n]   = mapply(k2, m_be[n], hi) | ev_buserr[n];
                    m_frz[n]  = mapply(k3, m_frz[n], lo);
                    m_sema[n] = (m_sema[n]
                                 + ((bus_wen && bus_addr == 12'(32'h140 + n*32'h70)) ? int'(bus_wdata[7:0]) : 0)
                                 - ((sema_dec[n] && m_sema[n] != 0) ? 1 : 0)) & 255;
                end
                if (bus_wen && bus_addr == 12'(32'h110 + n*32'h70)) m_cmd[n] = bus_wdata;
            end
        end
    end

    function automatic logic [31:0] m_read(logic [11:0] a);
        logic [31:0] v = '0;
        if (a < 12'h040 && (a[3:0] == 0 || a[3:0] == 4 || a[3:0] == 8)) begin
            case (a[5:4])
                2'd0: begin v[28] = m_b1; v[29] = m_b8; end
                2'd1: for (int n = 0; n < NCH; n++) begin v[n] = m_done[n]; v[16+n] = m_en[n]; end
                2'd2: for (int n = 0; n < NCH; n++) begin v[n] = m_term[n]; v[16+n] = m_be[n]; end
                default: for (int n = 0; n < NCH; n++) begin v[n] = m_frz[n]; v[16+n] = m_rst[n]; end
            endcase
        end
        for (int n = 0; n < NCH; n++) begin
            if (a == 12'(32'h110 + n*32'h70)) v = m_cmd[n];
            if (a == 12'(32'h140 + n*32'h70)) v = 32'(m_sema[n]);
        end
        return v;
    endfunction

    function automatic string rd_req(logic [11:0] a);
        if (!rst_n) return "R1";
        if (a < 12'h040) begin
            if (a[3:0] != 0) return "R2";
            case (a[5:4])
                2'd0: return "R10";
                2'd1: return "R3";
                2'd2: return "R4";
                default: return "R7";
            endcase
        end
        for (int n = 0; n < NCH; n++)
            if (a == 12'(32'h110 + n*32'h70) || a == 12'(32'h140 + n*32'h70)) return "R9";
        return "R11";
    endfunction

    task automatic cmp(string req, string what, logic [511:0] act, logic [511:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compares every output against the model; called away from the active edge.
    task automatic check_all();
        logic [NCH-1:0] e_err, e_frz, e_rst, e_nz;
        logic [NCH*32-1:0] e_cmd;
        bit e_irq = 0;
        string rq = rst_n ? "" : "R1 ";
        for (int n = 0; n < NCH; n++) begin
            e_err[n] = m_err(n); e_frz[n] = m_frz[n]; e_rst[n] = m_rst[n];
            e_nz[n] = (m_sema[n] != 0); e_cmd[n*32 +: 32] = m_cmd[n];
            if ((m_done[n] && m_en[n]) || e_err[n]) e_irq = 1;
        end
        cmp({rq, "R6"}, "irq", 512'(irq), 512'(e_irq));
        cmp({rq, "R5"}, "chan_err", 512'(chan_err), 512'(e_err));
        cmp({rq, "R7"}, "chan_freeze", 512'(chan_freeze), 512'(e_frz));
        cmp({rq, "R8"}, "chan_reset", 512'(chan_reset), 512'(e_rst));
        cmp({rq, "R9"}, "chan_sema_nz", 512'(chan_sema_nz), 512'(e_nz));
        cmp({rq, "R9"}, "chan_cmd_addr", 512'(chan_cmd_addr), 512'(e_cmd));
        cmp({rq, "R10"}, "burst", 512'({burst8_en, burst_en}), 512'({m_b8, m_b1}));
        cmp(rd_req(bus_addr), $sformatf("rdata@%03h", bus_addr), 512'(bus_rdata), 512'(m_read(bus_addr)));
    endtask

    // One cycle of stimulus followed by a full comparison.
    task automatic cyc(bit wen, logic [11:0] a, logic [31:0] d,
                       logic [NCH-1:0] dn = '0, logic [NCH-1:0] tm = '0,
                       logic [NCH-1:0] be = '0, logic [NCH-1:0] dc = '0);
        bus_wen = wen; bus_addr = a; bus_wdata = d;
        ev_done = dn; ev_term = tm; ev_buserr = be; sema_dec = dc;
        @(negedge clk);
        check_all();
    endtask

    task automatic rd(logic [11:0] a);
        cyc(0, a, '0);
    endtask

    initial begin
        #(WD_CYC * 5.0);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(1, 12'h004, 32'hFFFF_FFFF, '1, '1, '1, '1);
        rst_n = 1'b1;
        rd(12'h010); rd(12'h020); rd(12'h030); rd(12'h000);
        // R10: burst bits via aliases
        cyc(1, 12'h004, 32'h1000_0000); rd(12'h000);
        cyc(1, 12'h000, 32'hFFFF_FFFF); rd(12'h008);
        cyc(1, 12'h008, 32'h1000_0000); rd(12'h004);
        // R3/R6: enable ch0..3, completion on ch2, clear by alias
        cyc(1, 12'h014, 32'h000F_0000); cyc(0, 12'h010, 0, 16'h0004); rd(12'h010);
        cyc(1, 12'h018, 32'h0000_0004); rd(12'h010);
        // R3: event wins over a same-cycle clear
        cyc(0, 12'h010, 0, 16'h0020); cyc(1, 12'h018, 32'h0000_0020, 16'h0020); rd(12'h010);
        // R5: lone terminate, then completion makes it benign
        cyc(0, 12'h020, 0, 0, 16'h0080); rd(12'h020); cyc(0, 12'h020, 0, 16'h0080); rd(12'h020);
        // R5: terminate together with completion
        cyc(0, 12'h020, 0, 16'h0100, 16'h0100); rd(12'h024);
        // R4/R5: bus error together with completion
        cyc(0, 12'h020, 0, 16'h0200, 0, 16'h0200); rd(12'h028);
        cyc(1, 12'h028, 32'hFFFF_FFFF); rd(12'h020);
        // R7: freeze set and clear aliases
        cyc(1, 12'h034, 32'h0000_0300); cyc(1, 12'h038, 32'h0000_0100); rd(12'h030);
        // R9: pointer and semaphore of ch3 and ch15
        cyc(1, 12'h260, 32'hDEAD_BEE0); rd(12'h260);
        cyc(1, 12'h290, 32'h0000_0002); cyc(0, 12'h290, 0, 0, 0, 0, 16'h0008);
        cyc(0, 12'h290, 0, 0, 0, 0, 16'h0008); cyc(0, 12'h290, 0, 0, 0, 0, 16'h0008); rd(12'h290);
        cyc(1, 12'h7A0, 32'h1234_5678); cyc(1, 12'h7D0, 32'h0000_0005); rd(12'h7D0);
        // R8: reset of ch9 with state loaded
        cyc(1, 12'h034, 32'h0000_0200); cyc(0, 12'h020, 0, 16'h0200, 16'h0200, 16'h0200);
        cyc(1, 12'h034, 32'h0200_0000); rd(12'h030); rd(12'h020); rd(12'h010);
        // R2/R11: ignored addresses
        cyc(1, 12'h00C, 32'hFFFF_FFFF); cyc(1, 12'h01C, 32'hFFFF_FFFF);
        cyc(1, 12'h800, 32'hFFFF_FFFF); cyc(1, 12'h100, 32'hFFFF_FFFF); rd(12'h010); rd(12'h000);
        // Mixed random traffic, compared every cycle.
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom % 9;
            logic [11:0] a;
            bit w = 1;
            int ch = $urandom % NCH;
            case (sel)
                0, 1, 2, 3: a = 12'((sel << 4) | (($urandom % 4) << 2));
                4: a = 12'(32'h110 + ch*32'h70);
                5: a = 12'(32'h140 + ch*32'h70);
                6: a = 12'($urandom);
                default: begin a = 12'($urandom % 12'h800); w = 0; end
            endcase
            cyc(w && ($urandom % 3 != 0), a, $urandom & ($urandom | 32'h0000_00FF),
                16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
                16'($urandom & $urandom & $urandom & $urandom), 16'($urandom & $urandom));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule